// File: doc/BRIEF.md
# Telemetry Statistics Engine

This block turns a stream of tagged measurement samples into derived telemetry. Each sample carries a two-bit tag that names its channel: input voltage, output voltage, input current or temperature. For every channel the block keeps the statistics that channel needs. These are a running peak, a running minimum and a block average taken over a programmable number of samples.

It also forms an instantaneous input-power value from the latest input-voltage and input-current samples. It tracks the average and peak of that power and adds every power value into a saturating energy total. A single host write sets the averaging length and clears the peaks, minimums and averages. All results sit in registers that a host bus can read.

Top module: `telem_stats`

## Requirements
- R1: After reset every peak and average output is 0, `vin_min` and `vout_min` are all ones (full scale), `pwr_now` and `energy` are 0, and the block length is 1 sample.
- R2: A sample is taken only in a cycle where `smp_valid` is 1. `smp_tag` value 0 means input voltage, 1 means output voltage, 2 means input current and 3 means temperature. A cycle with `smp_valid` at 0 changes no output.
- R3: `vin_pk`, `iin_pk` and `tmp_pk` hold the largest sample of their channel since the last clear. `pwr_pk` holds the largest power value since the last clear. Each one is visible in the cycle after the sample.
- R4: `vin_min` and `vout_min` hold the smallest sample of their channel since the last clear. Each one is visible in the cycle after the sample.
- R5: Each average output updates only when a block of N samples of its own channel is complete. It then shows floor(sum/N) in the next cycle and keeps that value until the next block completes.
- R6: Every input-voltage or input-current sample produces one power value. It is the product of the newest input voltage and the newest input current, and the sample being taken counts as the newest of its kind. It appears on `pwr_now` in the next cycle and feeds `pwr_avg` (blocks of N power values) and `pwr_pk`.
- R7: `energy` adds every power value and stops at 2^32-1. A configuration write does not clear it.
- R8: A write (`cfg_we` = 1) loads `cfg_avg_log` = k and sets N = 2^k, with k from 0 to 7. The same write resets peaks to 0, minimums to full scale and averages to 0, and throws away any partly filled block. A sample presented in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_tag | input | 2 | Channel tag of the sample |
| smp_data | input | DW | Sample value, unsigned |
| cfg_we | input | 1 | Configuration write strobe, also clears statistics |
| cfg_avg_log | input | 3 | log2 of the averaging length |
| vin_avg | output | DW | Input-voltage block average |
| vin_pk | output | DW | Input-voltage peak |
| vin_min | output | DW | Input-voltage minimum |
| vout_avg | output | DW | Output-voltage block average |
| vout_min | output | DW | Output-voltage minimum |
| iin_avg | output | DW | Input-current block average |
| iin_pk | output | DW | Input-current peak |
| tmp_avg | output | DW | Temperature block average |
| tmp_pk | output | DW | Temperature peak |
| pwr_now | output | 2*DW | Latest power value |
| pwr_avg | output | 2*DW | Power block average |
| pwr_pk | output | 2*DW | Power peak |
| energy | output | EW | Saturating energy total |

## Verification
A mixed sequence with a block length of two interleaves all four tags. It rises and falls within channels, which separates each peak from each minimum and shows that one channel never disturbs another. The same sequence shows that an average holds between blocks. Pairing a voltage step with a later current step checks that power uses the newest value of each operand.

Block lengths of 1 and 128 exercise both ends of the shift range. A long run at full-scale operands drives the energy total into saturation. A clearing write is issued together with a sample to show that the sample is dropped and that the energy total survives the write.

// File: rtl/telem_stats.sv
module telem_stats #(
  parameter int DW = 10,
  parameter int EW = 32,
  parameter int LW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [1:0]      smp_tag,
  input  logic [DW-1:0]   smp_data,
  input  logic            cfg_we,
  input  logic [LW-1:0]   cfg_avg_log,
  output logic [DW-1:0]   vin_avg,
  output logic [DW-1:0]   vin_pk,
  output logic [DW-1:0]   vin_min,
  output logic [DW-1:0]   vout_avg,
  output logic [DW-1:0]   vout_min,
  output logic [DW-1:0]   iin_avg,
  output logic [DW-1:0]   iin_pk,
  output logic [DW-1:0]   tmp_avg,
  output logic [DW-1:0]   tmp_pk,
  output logic [2*DW-1:0] pwr_now,
  output logic [2*DW-1:0] pwr_avg,
  output logic [2*DW-1:0] pwr_pk,
  output logic [EW-1:0]   energy
);
  localparam int PW   = 2 * DW;
  localparam int CNTW = 1 << LW;
  localparam int AW   = PW + CNTW - 1;
  localparam int NL   = 5;

  logic [LW-1:0]   avg_log;
  logic [DW-1:0]   last_v, last_i;
  logic            take;
  logic [DW-1:0]   v_op, i_op;
  logic [PW-1:0]   pwr_next;
  logic [EW:0]     e_sum;
  logic [CNTW-1:0] nblk;
  logic [NL-1:0]   hit;
  logic [NL-1:0][PW-1:0] lval;

  assign take     = smp_valid && !cfg_we;
  assign v_op     = (smp_tag == 2'd0) ? smp_data : last_v;
  assign i_op     = (smp_tag == 2'd2) ? smp_data : last_i;
  assign pwr_next = v_op * i_op;
  assign e_sum    = {1'b0, energy} + {{(EW + 1 - PW){1'b0}}, pwr_next};
  assign nblk     = CNTW'(1) << avg_log;

  assign hit[0] = take && smp_tag == 2'd0;
  assign hit[1] = take && smp_tag == 2'd1;
  assign hit[2] = take && smp_tag == 2'd2;
  assign hit[3] = take && smp_tag == 2'd3;
  assign hit[4] = hit[0] || hit[2];
  assign lval[0] = {{(PW - DW){1'b0}}, smp_data};
  assign lval[1] = lval[0];
  assign lval[2] = lval[0];
  assign lval[3] = lval[0];
  assign lval[4] = pwr_next;

  for (genvar l = 0; l < NL; l++) begin : lane
    logic [AW-1:0]   acc;
    logic [AW-1:0]   sum;
    logic [AW-1:0]   shifted;
    logic [CNTW-1:0] cnt;
    logic [PW-1:0]   avg_q;

    assign sum     = acc + {{(AW - PW){1'b0}}, lval[l]};
    assign shifted = sum >> avg_log;

    always_ff @(posedge clk) begin
      if (!rst_n || cfg_we) begin
        acc   <= '0;
        cnt   <= '0;
        avg_q <= '0;
      end else if (hit[l]) begin
        if (cnt == nblk - 1'b1) begin
          avg_q <= shifted[PW-1:0];
          acc   <= '0;
          cnt   <= '0;
        end else begin
          acc <= sum;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign vin_avg  = lane[0].avg_q[DW-1:0];
  assign vout_avg = lane[1].avg_q[DW-1:0];
  assign iin_avg  = lane[2].avg_q[DW-1:0];
  assign tmp_avg  = lane[3].avg_q[DW-1:0];
  assign pwr_avg  = lane[4].avg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avg_log <= '0;
      last_v  <= '0;
      last_i  <= '0;
      pwr_now <= '0;
      energy  <= '0;
    end else if (cfg_we) begin
      avg_log <= cfg_avg_log;
    end else if (hit[4]) begin
      last_v  <= v_op;
      last_i  <= i_op;
      pwr_now <= pwr_next;
      energy  <= e_sum[EW] ? '1 : e_sum[EW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_we) begin
      vin_pk   <= '0;
      iin_pk   <= '0;
      tmp_pk   <= '0;
      pwr_pk   <= '0;
      vin_min  <= '1;
      vout_min <= '1;
    end else begin
      if (hit[0] && smp_data > vin_pk)   vin_pk   <= smp_data;
      if (hit[0] && smp_data < vin_min)  vin_min  <= smp_data;
      if (hit[1] && smp_data < vout_min) vout_min <= smp_data;
      if (hit[2] && smp_data > iin_pk)   iin_pk   <= smp_data;
      if (hit[3] && smp_data > tmp_pk)   tmp_pk   <= smp_data;
      if (hit[4] && pwr_next > pwr_pk)   pwr_pk   <= pwr_next;
    end
  end
endmodule

// File: rtl/telem_stats_chk.sv
module telem_stats_chk #(
  parameter int DW = 10,
  parameter int EW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [1:0]    smp_tag,
  input logic [DW-1:0] smp_data,
  input logic          cfg_we,
  input logic [DW-1:0] vin_pk,
  input logic [DW-1:0] vin_min,
  input logic [DW-1:0] vout_min,
  input logic [EW-1:0] energy
);
  // R3
  pk_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> vin_pk >= $past(vin_pk));

  // R3
  pk_covers_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_tag == 2'd0 && !cfg_we) |=> vin_pk >= $past(smp_data));

  // R4
  min_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> vin_min <= $past(vin_min));

  // R2
  tag_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_tag == 2'd1 && !cfg_we) |=> ($stable(vin_pk) && $stable(vin_min)));

  // R7
  energy_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> energy >= $past(energy));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (vin_pk == '0 && vin_min == '1 && vout_min == '1));
endmodule

bind telem_stats telem_stats_chk #(.DW(DW), .EW(EW)) u_chk (.*);

// File: tb/telem_stats_bench.sv
module telem_stats_bench;
  localparam int CLK_P = 10;
  localparam int DW = 10;
  localparam int PW = 2 * DW;
  localparam int EW = 32;
  localparam int NV = 10;

  logic clk = 0, rst_n = 0, smp_valid = 0, cfg_we = 0;
  logic [1:0] smp_tag = '0;
  logic [DW-1:0] smp_data = '0;
  logic [2:0] cfg_avg_log = '0;
  logic [DW-1:0] vin_avg, vin_pk, vin_min, vout_avg, vout_min, iin_avg, iin_pk, tmp_avg, tmp_pk;
  logic [PW-1:0] pwr_now, pwr_avg, pwr_pk;
  logic [EW-1:0] energy;
  int total = 0, bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  telem_stats u_telem_stats (.*);

  // {tag, data, output selector, expected}, block length 2
  localparam logic [1:0][0:0] DUMMY = '0;
  localparam logic [63:0] VEC [NV] = '{
    {2'd0, 14'd100, 16'd2, 32'd100},
    {2'd0, 14'd300, 16'd0, 32'd200},
    {2'd2, 14'd10,  16'd9, 32'd3000},
    {2'd2, 14'd20,  16'd10, 32'd4500},
    {2'd1, 14'd500, 16'd4, 32'd500},
    {2'd1, 14'd400, 16'd3, 32'd450},
    {2'd3, 14'd70,  16'd8, 32'd70},
    {2'd3, 14'd50,  16'd7, 32'd60},
    {2'd0, 14'd50,  16'd0, 32'd200},
    {2'd2, 14'd5,   16'd10, 32'd625}
  };

  function automatic logic [31:0] pick(input int s);
    case (s)
      0: return 32'(vin_avg);   1: return 32'(vin_pk);   2: return 32'(vin_min);
      3: return 32'(vout_avg);  4: return 32'(vout_min); 5: return 32'(iin_avg);
      6: return 32'(iin_pk);    7: return 32'(tmp_avg);  8: return 32'(tmp_pk);
      9: return 32'(pwr_now);   10: return 32'(pwr_avg); 11: return 32'(pwr_pk);
      default: return energy;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] t, input logic [DW-1:0] d);
    smp_valid = 1; smp_tag = t; smp_data = d;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic cfg(input logic [2:0] k, input bit with_smp);
    cfg_we = 1; cfg_avg_log = k;
    if (with_smp) begin smp_valid = 1; smp_tag = 2'd0; smp_data = 10'd900; end
    @(negedge clk);
    cfg_we = 0; smp_valid = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(vin_min), 32'd1023);
    check("R1", 32'(vin_pk), 32'd0);
    check("R1", energy, 32'd0);
    // R1 block length 1 after reset
    send(2'd3, 10'd33);
    check("R1", 32'(tmp_avg), 32'd33);

    cfg(3'd1, 0);
    check("R8", 32'(tmp_pk), 32'd0);
    // R3 R4 R5 R6 R7 table walk
    for (int n = 0; n < NV; n++) begin
      send(VEC[n][63:62], VEC[n][57:48]);
      check($sformatf("R3-6 vec%0d", n), pick(int'(VEC[n][47:32])), VEC[n][31:0]);
    end
    check("R3", 32'(vin_pk), 32'd300);
    check("R4", 32'(vin_min), 32'd50);
    check("R3", 32'(pwr_pk), 32'd6000);
    check("R3", 32'(iin_pk), 32'd20);
    check("R7", energy, 32'd10250);

    // R2 valid low ignored
    smp_tag = 2'd0; smp_data = 10'd1000;
    @(negedge clk);
    check("R2", 32'(vin_pk), 32'd300);
    check("R2", 32'(pwr_now), 32'd250);

    // R8 clear with simultaneous sample dropped; energy kept
    cfg(3'd0, 1);
    check("R8", 32'(vin_pk), 32'd0);
    check("R8", 32'(vin_min), 32'd1023);
    check("R8", 32'(vin_avg), 32'd0);
    check("R8", 32'(pwr_pk), 32'd0);
    check("R7", energy, 32'd10250);
    send(2'd0, 10'd7);
    check("R5", 32'(vin_avg), 32'd7);

    // R5 block length 128
    cfg(3'd7, 0);
    for (int n = 0; n < 127; n++) send(2'd3, 10'd9);
    check("R5", 32'(tmp_avg), 32'd0);
    send(2'd3, 10'd9);
    check("R5", 32'(tmp_avg), 32'd9);

    // R7 saturation at full-scale operands
    send(2'd0, 10'd1023);
    for (int n = 0; n < 4200; n++) send(2'd2, 10'd1023);
    check("R6", 32'(pwr_now), 32'd1046529);
    check("R7", energy, 32'hFFFF_FFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule